// File: doc/BRIEF.md
# Burst Preamble Word Aligner

The aligner sits behind a 1:40 deserializer. A new 40-bit word arrives on every clock, and a burst can begin at any bit inside a word. While it is hunting, the block examines an 80-bit window made of the previous word and the current word. It tests the configured 8-bit start pattern at each of the 40 starting positions that fall in the previous word, all in the same clock.

On a hit, the block records the bit position and asserts `alignedValid`. From then on it re-slices the stream with a barrel shift, so the start pattern, and every 40 bits after it, lands on a fixed word boundary. The start pattern always occupies the top byte of the first aligned word. The recorded position is held until `burstEnd` arrives. The block then returns to hunting for the next burst.

Top module: `burst_aligner`

## Requirements
- R1: The stream is sent MSB first. Bit 39 of `dataIn` is the earliest bit of a word, and the word sampled at one clock edge comes before the word sampled at the next edge.
- R2: While hunting, the start pattern is found at every bit position 0..39 of a word, where position 0 is bit 39. This includes positions 33..39, where the pattern continues into the following word.
- R3: The first word with `alignedValid` high carries the start pattern in `dataOut[39:32]`. Each later valid word carries the next 40 stream bits in order.
- R4: A start pattern that begins in the word sampled at edge t gives its first aligned word after edge t+1, which is a latency of two clocks.
- R5: When several positions in the window match, the position earliest in the stream wins, which is the lowest offset.
- R6: While locked, `lockOffset` shows the position of the pattern's first bit in its word and stays stable. Further copies of the start pattern in the payload neither move the alignment nor change `lockOffset`.
- R7: When `burstEnd` is high at an edge while locked, `alignedValid` is low after that edge. Hunting starts again at the next edge, over the window {word sampled with `burstEnd`, following word}.
- R8: `burstEnd` has no effect while hunting.
- R9: After reset, and whenever `alignedValid` is low, `dataOut` is zero. Reset also clears `lockOffset`.
- R10: The start pattern is the parameter `PREAMBLE`, whose default is 8'hA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 40 | Deserialized word, bit 39 earliest |
| burstEnd | input | 1 | Releases the lock and restarts the hunt |
| dataOut | output | 40 | Realigned word |
| alignedValid | output | 1 | High from the start-pattern word onward |
| lockOffset | output | 6 | Held bit offset of the current lock |

## Verification
The bench places the start pattern at offset 0 and at the straddling offsets 37 and 39. A design that ignores the second word of the window would never lock at those offsets, or would slice the wrong bits. A word with two copies of the pattern catches a priority encoder that favours the highest offset. A payload copy placed after lock catches a design that keeps searching while locked.

One stream ends a burst and then carries a second burst at a new offset. This checks that the hunt resumes at the right window with no stray valid word in between. A `burstEnd` pulse sent before any pattern must leave the later lock unchanged.

// File: rtl/burst_align_pkg.sv
package burst_align_pkg;
  // strobes issued by the control to the datapath each clock
  typedef struct packed {
    logic capture;  // store the offset found this cycle
    logic useHeld;  // slice with the stored offset
    logic emit;     // present an aligned word
  } alignCtrl_t;
endpackage

// File: rtl/preamble_search.sv
module preamble_search #(
  parameter int WORD_W = 40,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'hA5,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input  logic [2*WORD_W-1:0] window,
  output logic                hitAny,
  output logic [OFF_W-1:0]    hitOff
);
  logic [WORD_W-1:0] hit;

  // one comparator per starting bit in the older word
  for (genvar k = 0; k < WORD_W; k++) begin : g_cmp
    assign hit[k] = (window[2*WORD_W-1-k -: PRE_W] == PREAMBLE);
  end

  assign hitAny = |hit;

  // lowest offset is earliest in the stream and wins
  always_comb begin
    hitOff = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (hit[k]) hitOff = OFF_W'(k);
    end
  end
endmodule

// File: rtl/align_datapath.sv
module align_datapath
  import burst_align_pkg::*;
#(
  parameter int WORD_W = 40,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'hA5,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] dataIn,
  input  alignCtrl_t        ctrl,
  output logic              hitAny,
  output logic [WORD_W-1:0] dataOut,
  output logic              alignedValid,
  output logic [OFF_W-1:0]  lockOffset
);
  logic [WORD_W-1:0]   prevWord;
  logic [2*WORD_W-1:0] window;
  logic [2*WORD_W-1:0] shifted;
  logic [OFF_W-1:0]    hitOff;
  logic [OFF_W-1:0]    heldOff;
  logic [OFF_W-1:0]    selOff;

  assign window = {prevWord, dataIn};

  preamble_search #(
    .WORD_W(WORD_W), .PRE_W(PRE_W), .PREAMBLE(PREAMBLE)
  ) i_search (
    .window(window),
    .hitAny(hitAny),
    .hitOff(hitOff)
  );

  assign selOff  = ctrl.useHeld ? heldOff : hitOff;
  assign shifted = window << selOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord     <= '0;
      heldOff      <= '0;
      dataOut      <= '0;
      alignedValid <= 1'b0;
    end else begin
      prevWord     <= dataIn;
      if (ctrl.capture) heldOff <= hitOff;
      dataOut      <= ctrl.emit ? shifted[2*WORD_W-1:WORD_W] : '0;
      alignedValid <= ctrl.emit;
    end
  end

  assign lockOffset = heldOff;
endmodule

// File: rtl/align_control.sv
module align_control
  import burst_align_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hitAny,
  input  logic       burstEnd,
  output alignCtrl_t ctrl
);
  typedef enum logic {HUNT, LOCKED} state_t;
  state_t state;

  always_comb begin
    ctrl.capture = (state == HUNT) && hitAny;
    ctrl.useHeld = (state == LOCKED);
    ctrl.emit    = ctrl.capture || ((state == LOCKED) && !burstEnd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= HUNT;
    end else begin
      unique case (state)
        HUNT:   if (hitAny)   state <= LOCKED;
        LOCKED: if (burstEnd) state <= HUNT;
        default: state <= HUNT;
      endcase
    end
  end
endmodule

// File: rtl/burst_aligner.sv
module burst_aligner
  import burst_align_pkg::*;
#(
  parameter int WORD_W = 40,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'hA5,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              burstEnd,
  output logic [WORD_W-1:0] dataOut,
  output logic              alignedValid,
  output logic [OFF_W-1:0]  lockOffset
);
  alignCtrl_t ctrl;
  logic       hitAny;

  align_control i_ctrl (
    .clk(clk), .rstN(rstN), .hitAny(hitAny), .burstEnd(burstEnd), .ctrl(ctrl)
  );

  align_datapath #(
    .WORD_W(WORD_W), .PRE_W(PRE_W), .PREAMBLE(PREAMBLE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .ctrl(ctrl), .hitAny(hitAny),
    .dataOut(dataOut), .alignedValid(alignedValid), .lockOffset(lockOffset)
  );
endmodule

// File: rtl/burst_aligner_chk.sv
module burst_aligner_chk #(
  parameter int WORD_W = 40,
  parameter int PRE_W = 8,
  parameter logic [PRE_W-1:0] PREAMBLE = 8'hA5,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] dataIn,
  input logic              burstEnd,
  input logic [WORD_W-1:0] dataOut,
  input logic              alignedValid,
  input logic [OFF_W-1:0]  lockOffset
);
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !alignedValid |-> dataOut == '0);

  p_top_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alignedValid) |-> dataOut[WORD_W-1 -: PRE_W] == PREAMBLE);

  p_offset_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    alignedValid && $past(alignedValid) |-> $stable(lockOffset));

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    alignedValid && burstEnd |=> !alignedValid);

  p_offset_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(lockOffset) < WORD_W);
endmodule

bind burst_aligner burst_aligner_chk #(
  .WORD_W(WORD_W), .PRE_W(PRE_W), .PREAMBLE(PREAMBLE)
) i_chk (
  .clk(clk), .rstN(rstN), .dataIn(dataIn), .burstEnd(burstEnd),
  .dataOut(dataOut), .alignedValid(alignedValid), .lockOffset(lockOffset)
);

// File: tb/test_burst_aligner.sv
module test_burst_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int W = 40;
  localparam int NB = W * 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic         burstEnd = 1'b0;
  logic [W-1:0] dataOut;
  logic         alignedValid;
  logic [5:0]   lockOffset;

  logic [0:NB-1] strm;  // index 0 is the earliest bit
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  burst_aligner i_burst_aligner (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .burstEnd(burstEnd),
    .dataOut(dataOut), .alignedValid(alignedValid), .lockOffset(lockOffset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, got %0d cycles, expected fewer", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic putPre(input int pos);
    strm[pos +: 8] = 8'hA5;  // R10 default pattern
  endtask

  task automatic fill(input int from, input int to);
    for (int i = from; i < to; i++) strm[i] = ((i * 13) % 7 < 3);
  endtask

  // R9: reset state
  task automatic doReset();
    rstN = 1'b0; dataIn = '0; burstEnd = 1'b0; strm = '0;
    repeat (2) @(negedge clk);
    check(alignedValid == 1'b0, "R9 reset valid", W'(alignedValid), '0);
    check(dataOut == '0, "R9 reset data", dataOut, '0);
    check(lockOffset == '0, "R9 reset offset", W'(lockOffset), '0);
    rstN = 1'b1;
  endtask

  // Plays nWords words; burst 1 at bit p1 released by burstEnd with word end1,
  // burst 2 at bit p2 (or -1); hEnd pulses burstEnd while hunting.
  task automatic play(input int nWords, input int p1, input int end1,
                      input int p2, input int hEnd, input string tag);
    for (int c = 0; c < nWords + 3; c++) begin
      logic         ev;
      logic [W-1:0] ed;
      int           k;
      @(negedge clk);
      ev = 1'b0; ed = '0; k = 0;
      if (p1 >= 0 && c >= p1 / W + 2 && (end1 < 0 || c < end1 + 1)) begin
        ev = 1'b1; k = p1 % W;
      end else if (p2 >= 0 && c >= p2 / W + 2) begin
        ev = 1'b1; k = p2 % W;
      end
      if (ev) ed = strm[W*(c-2)+k +: W];
      check(alignedValid == ev, {tag, " valid"}, W'(alignedValid), W'(ev));
      check(dataOut == ed, {tag, " data"}, dataOut, ed);
      if (ev) check(lockOffset == 6'(k), {tag, " offset"}, W'(lockOffset), W'(k));
      dataIn   = (c < nWords) ? strm[W*c +: W] : '0;
      burstEnd = (c == end1) || (c == hEnd);
    end
    burstEnd = 1'b0;
  endtask

  task automatic t_offset0();  // R1 R3 R4
    doReset();
    putPre(W*2); fill(W*2 + 8, W*8);
    play(8, W*2, -1, -1, -1, "R1/R3/R4 offset0");
  endtask

  task automatic t_straddle();  // R2
    doReset();
    putPre(W*3 + 37); fill(W*3 + 45, W*9);
    play(9, W*3 + 37, -1, -1, -1, "R2 offset37");
    doReset();
    putPre(W*1 + 39); fill(W*1 + 47, W*7);
    play(7, W*1 + 39, -1, -1, -1, "R2 offset39");
  endtask

  task automatic t_priority();  // R5
    doReset();
    fill(W*2 + 11, W*8);
    putPre(W*2 + 3); putPre(W*2 + 20);
    play(8, W*2 + 3, -1, -1, -1, "R5 lowest");
  endtask

  task automatic t_hold();  // R6: payload copy of the pattern ignored
    doReset();
    putPre(W*1 + 5); fill(W*1 + 13, W*9);
    putPre(W*4 + 22); putPre(W*6 + 1);
    play(9, W*1 + 5, -1, -1, -1, "R6 held");
  endtask

  task automatic t_reacquire();  // R7
    doReset();
    putPre(W*1 + 10); fill(W*1 + 18, W*5);
    putPre(W*7 + 30); fill(W*7 + 38, W*13);
    play(13, W*1 + 10, 5, W*7 + 30, -1, "R7 reacquire");
  endtask

  task automatic t_huntEnd();  // R8
    doReset();
    putPre(W*4 + 17); fill(W*4 + 25, W*10);
    play(10, W*4 + 17, -1, -1, 2, "R8 hunt end");
  endtask

  initial begin
    t_offset0();
    t_straddle();
    t_priority();
    t_hold();
    t_reacquire();
    t_huntEnd();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule